// File: doc/BRIEF.md
# ADC Serial Result Formatter

This block takes each 12-bit result from a converter's successive-approximation logic and sends it out over a three-wire serial link. The three wires are a serial clock, a serial data line and an active-low frame strobe. Every wire is open-drain. The block reports, for each wire, whether it pulls the line low. A released line floats high through its external pull-up. The serial clock is the converter clock divided down, and its high and low phases have equal length.

A two-bit format code, which stands for a three-level mode pin, picks how the port behaves:

- **Parallel-only mode:** the port stays silent.
- **Gated-clock mode:** the serial clock runs only while a word is pending or being sent. It parks released (high) otherwise.
- **Continuous-clock mode:** the serial clock toggles all the time, and words are framed against it.

The conversion logic gives a one-cycle result-ready pulse together with the result. Results that arrive while a word is still pending or on the wire are dropped.

Top module: `sof_top`

## Requirements
- R1: The format code selects the mode. `2'b01` is parallel-only, `2'b00` is gated clock and `2'b10` is continuous clock. `2'b11` behaves as parallel-only. In parallel-only mode all three lines are released and a result-ready pulse starts no frame.
- R2: While the serial clock runs, its period is 2*SCLK_HALF converter clock cycles. The high phase and the low phase each last SCLK_HALF cycles.
- R3: In gated mode, when no word is pending or being sent, the serial clock is released (high) and does not toggle.
- R4: In continuous mode the serial clock toggles even when no word is being sent.
- R5: A frame starts on a falling edge of the serial clock, where the strobe goes low. The first data-sampling falling edge comes exactly one serial clock period (2*SCLK_HALF cycles) later.
- R6: The 12 bits go out most significant bit first, one bit per serial clock period. The data line changes only together with a rising serial clock edge, so each bit is stable at the falling edge that follows it. The receiver reads the bits on the 12 falling edges after the lead edge.
- R7: Both the strobe and the data line are released at the rising edge that follows the twelfth sampling falling edge.
- R8: A result-ready pulse that arrives while a word is pending or in flight is ignored. No frame is ever sent for it.
- R9: Outside a frame the data line is released (high).
- R10: While reset is asserted, all three lines are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; the serial clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Format code (01 parallel-only, 00 gated, 10 continuous, 11 parallel-only) |
| res_vld_i | input | 1 | One-cycle result-ready pulse |
| res_i | input | 12 | Conversion result |
| sclk_pd_o | output | 1 | 1 = pull serial clock line low, 0 = release |
| sdata_pd_o | output | 1 | 1 = pull serial data line low, 0 = release |
| fs_pd_o | output | 1 | 1 = pull frame strobe line low (frame active), 0 = release |

## Verification
In continuous mode, the arrival of a result and a falling edge of the free-running serial clock can land in the same converter clock cycle. A result can also arrive in the same cycle in which the previous frame releases its strobe.

The bench provokes the first case by sweeping the result-ready pulse across every cycle offset inside one serial clock period. Each of those frames is then judged on three points: the lead interval from strobe fall to first sampling edge is exactly one period, the bits come out in the right order, and the data changes only on rising edges. Pulses that land on a busy frame are judged by the frame count and by the scoreboard queue draining empty.

// File: rtl/sof_pkg.sv
package sof_pkg;

    typedef enum logic [1:0] {
        FMT_GATED    = 2'b00,
        FMT_PARALLEL = 2'b01,
        FMT_CONT     = 2'b10
    } fmt_e;

    typedef struct packed {
        logic level;  // current serial clock level, 1 = released/high
        logic rise;   // level goes high at the coming edge
        logic fall;   // level goes low at the coming edge
    } sclk_evt_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_ARMED,
        SH_LEAD,
        SH_SHIFT
    } sh_state_e;

    function automatic fmt_e decode_fmt(input logic [1:0] code);
        case (code)
            2'b00:   return FMT_GATED;
            2'b10:   return FMT_CONT;
            default: return FMT_PARALLEL;
        endcase
    endfunction

endpackage

// File: rtl/sof_clkgen.sv
module sof_clkgen
    import sof_pkg::*;
#(
    parameter int SCLK_HALF = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output sclk_evt_t evt
);
    localparam int CNT_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SCLK_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             level_q;
    logic             tick;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else if (tick) begin
            cnt_q   <= '0;
            level_q <= ~level_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        evt.level = level_q;
        evt.rise  = tick && !level_q;
        evt.fall  = tick && level_q;
    end

    // R2: phase counter never passes the half-period limit
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3: a stopped divider parks the clock high
    p_park_high_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> level_q);

endmodule

// File: rtl/sof_shifter.sv
module sof_shifter
    import sof_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  logic              accept,
    input  logic [WORD_W-1:0] word,
    input  sclk_evt_t         evt,
    output logic              busy,
    output logic              data_low,
    output logic              strobe_low
);
    localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    sh_state_e         st_q;
    logic [WORD_W-1:0] sh_q;
    logic [BC_W-1:0]   bc_q;
    logic              dlow_q;
    logic              slow_q;

    always_ff @(posedge clk) begin
        if (rst || !ser_en) begin
            st_q   <= SH_IDLE;
            sh_q   <= '0;
            bc_q   <= '0;
            dlow_q <= 1'b0;
            slow_q <= 1'b0;
        end else begin
            case (st_q)
                SH_IDLE: begin
                    if (accept) begin
                        sh_q <= word;
                        st_q <= SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (evt.fall) begin
                        slow_q <= 1'b1;
                        st_q   <= SH_LEAD;
                    end
                end
                SH_LEAD: begin
                    if (evt.rise) begin
                        dlow_q <= ~sh_q[WORD_W-1];
                        sh_q   <= sh_q << 1;
                        bc_q   <= BC_W'(WORD_W - 1);
                        st_q   <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (evt.rise) begin
                        if (bc_q == '0) begin
                            dlow_q <= 1'b0;
                            slow_q <= 1'b0;
                            st_q   <= SH_IDLE;
                        end else begin
                            dlow_q <= ~sh_q[WORD_W-1];
                            sh_q   <= sh_q << 1;
                            bc_q   <= bc_q - 1'b1;
                        end
                    end
                end
                default: st_q <= SH_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != SH_IDLE);
    assign data_low   = dlow_q;
    assign strobe_low = slow_q;

    // R9: no frame in progress means both lines released
    p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == SH_IDLE || st_q == SH_ARMED) |-> (!dlow_q && !slow_q));

    // R8: a pulse while a word waits leaves the held word untouched
    p_hold_word_r8: assert property (@(posedge clk) disable iff (rst || !ser_en)
        (st_q == SH_ARMED && accept && !evt.fall) |=> (sh_q == $past(sh_q)));

endmodule

// File: rtl/sof_top.sv
module sof_top
    import sof_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int SCLK_HALF = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_i,
    input  logic              res_vld_i,
    input  logic [WORD_W-1:0] res_i,
    output logic              sclk_pd_o,
    output logic              sdata_pd_o,
    output logic              fs_pd_o
);
    fmt_e      fmt;
    logic      ser_en;
    logic      busy;
    logic      run;
    sclk_evt_t evt;
    logic      data_low;
    logic      strobe_low;

    assign fmt    = decode_fmt(fmt_i);
    assign ser_en = (fmt != FMT_PARALLEL);
    assign run    = ser_en && ((fmt == FMT_CONT) || busy);

    sof_clkgen #(.SCLK_HALF(SCLK_HALF)) u_clkgen (
        .clk (clk),
        .rst (rst),
        .run (run),
        .evt (evt)
    );

    sof_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .ser_en     (ser_en),
        .accept     (res_vld_i),
        .word       (res_i),
        .evt        (evt),
        .busy       (busy),
        .data_low   (data_low),
        .strobe_low (strobe_low)
    );

    assign sclk_pd_o  = ~evt.level;
    assign sdata_pd_o = data_low;
    assign fs_pd_o    = strobe_low;

    // R1: parallel-only mode releases every line on the next cycle
    p_par_released_r1: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_PARALLEL) |=> (!sclk_pd_o && !sdata_pd_o && !fs_pd_o));

    // R5: strobe goes active only together with a falling clock edge
    p_strobe_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_pd_o) |-> $rose(sclk_pd_o));

    // R6: data line moves only together with a rising clock edge
    p_data_on_rise_r6: assert property (@(posedge clk) disable iff (rst || !ser_en)
        ($past(ser_en) && !$stable(sdata_pd_o)) |-> $fell(sclk_pd_o));

    // R3: gated mode with nothing to send keeps the clock released
    p_gated_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_GATED && !busy && $past(fmt == FMT_GATED && !busy)) |-> !sclk_pd_o);

endmodule

// File: tb/sim_sof_top.sv
module sim_sof_top;
    localparam int W = 12;
    localparam int H = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   fmt;
    logic         wv;
    logic [W-1:0] wd;
    logic         sclk_pd, sdata_pd, fs_pd;

    always #4 clk = ~clk;

    sof_top #(.WORD_W(W), .SCLK_HALF(H)) u0 (
        .clk(clk), .rst(rst), .fmt_i(fmt), .res_vld_i(wv), .res_i(wd),
        .sclk_pd_o(sclk_pd), .sdata_pd_o(sdata_pd), .fs_pd_o(fs_pd)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] q[$];
    int frames = 0;
    int sclk_edges = 0;
    int cyc = 0;
    int mode_chg = 0;
    int last_fall = -1000, last_rise = -1000, sfall = 0;
    bit in_frame = 0;
    int nb = 0;
    logic [W-1:0] got;
    logic p_sclk = 1, p_sd = 1, p_fs = 1;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: samples pins mid-cycle and scores finished frames
    always @(negedge clk) begin
        logic sc, sd, fs, rose_s, fell_s;
        sc = ~sclk_pd; sd = ~sdata_pd; fs = ~fs_pd;
        cyc++;
        if (rst) begin
            in_frame = 0;
        end else begin
            rose_s = sc && !p_sclk;
            fell_s = !sc && p_sclk;
            if (rose_s || fell_s) sclk_edges++;
            if (rose_s) begin
                if (last_fall > mode_chg + 1)
                    chk(cyc - last_fall == H, "R2", "low phase length", cyc - last_fall, H);
                last_rise = cyc;
            end
            if (fell_s) begin
                if (in_frame && last_rise > mode_chg + 1)
                    chk(cyc - last_rise == H, "R2", "high phase length", cyc - last_rise, H);
                last_fall = cyc;
            end
            if (!fs && p_fs) begin
                chk(fell_s, "R5", "strobe fall on clock fall", fell_s, 1);
                in_frame = 1; nb = 0; got = '0; sfall = cyc;
            end else if (in_frame && fell_s && !fs) begin
                if (nb == 0)
                    chk(cyc - sfall == 2*H, "R5", "lead interval", cyc - sfall, 2*H);
                got = {got[W-2:0], sd};
                nb++;
            end
            if (sd != p_sd)
                chk(rose_s, "R6", "data change off rising edge", rose_s, 1);
            if (fs && !p_fs) begin
                chk(rose_s, "R7", "strobe release on rising edge", rose_s, 1);
                chk(nb == W, "R7", "bits per frame", nb, W);
                chk(sd, "R9", "data released after frame", sd, 1);
                frames++;
                if (q.size() == 0) chk(0, "R8", "unexpected frame", got, 0);
                else begin
                    logic [W-1:0] e;
                    e = q.pop_front();
                    chk(got == e, "R6", "frame word", got, e);
                end
                in_frame = 0;
            end
        end
        p_sclk = sc; p_sd = sd; p_fs = fs;
    end

    task automatic send(input logic [W-1:0] w, input bit expect_frame);
        @(negedge clk);
        wv = 1'b1; wd = w;
        if (expect_frame) q.push_back(w);
        @(negedge clk);
        wv = 1'b0;
    endtask

    task automatic wait_done();
        while (q.size() != 0 || in_frame) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        fmt = m;
        mode_chg = cyc;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int e0, f0;
        rst = 1; fmt = 2'b00; wv = 0; wd = '0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(!sclk_pd && !sdata_pd && !fs_pd, "R10", "lines released in reset",
            {sclk_pd, sdata_pd, fs_pd}, 0);
        rst = 0;

        // R3: gated idle clock parked high
        e0 = sclk_edges;
        repeat (40) @(negedge clk);
        chk(sclk_edges == e0 && !sclk_pd, "R3", "gated idle clock", sclk_edges - e0, 0);

        send(12'hA5A, 1); wait_done();
        send(12'hFFF, 1); wait_done();
        send(12'h000, 1); wait_done();
        send(12'h801, 1); wait_done();
        e0 = sclk_edges;
        repeat (30) @(negedge clk);
        chk(sclk_edges == e0 && !sclk_pd, "R3", "clock stops after frame", sclk_edges - e0, 0);

        // R8: pulses while armed and while shifting are dropped
        f0 = frames;
        send(12'h3C3, 1);
        send(12'h111, 0);
        repeat (40) @(negedge clk);
        send(12'h222, 0);
        wait_done();
        repeat (20*H) @(negedge clk);
        chk(frames == f0 + 1, "R8", "frames for busy pulses", frames - f0, 1);

        // R1: parallel-only modes (01 and 11)
        for (int m = 1; m <= 3; m += 2) begin
            set_mode(2'(m));
            f0 = frames; e0 = sclk_edges;
            send(12'h777, 0);
            repeat (100) @(negedge clk);
            chk(frames == f0, "R1", "frames in parallel mode", frames - f0, 0);
            chk(sclk_edges == e0, "R1", "clock edges in parallel mode", sclk_edges - e0, 0);
            chk(!sclk_pd && !sdata_pd && !fs_pd, "R1", "lines released in parallel mode",
                {sclk_pd, sdata_pd, fs_pd}, 0);
        end

        // R4: continuous clock toggles while idle
        set_mode(2'b10);
        repeat (20) @(negedge clk);
        e0 = sclk_edges;
        repeat (60) @(negedge clk);
        chk(sclk_edges - e0 >= 60/H - 1, "R4", "free-running edges", sclk_edges - e0, 60/H);

        // R5/R6: sweep arrival phase against the running clock
        for (int off = 0; off < 2*H; off++) begin
            repeat (off) @(negedge clk);
            send(W'(12'h800 >> off) ^ 12'h0F3, 1);
            wait_done();
        end

        set_mode(2'b00);
        repeat (20) @(negedge clk);
        send(12'h9C6, 1); wait_done();

        chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
        finish_run();
    end
endmodule